// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recent page translations so that most address lookups finish without a page-table walk. Each slot holds a virtual page number as its tag and a full page-table entry as its payload. A lookup compares the page number of the incoming virtual address against every valid slot at the same time. On a hit, the block returns the stored entry and the physical address in the same cycle. On a miss, it raises a miss flag.

After a miss, an external walker or software supplies the translation through the refill port. If the page is already cached, the refill overwrites that slot. Otherwise it takes a free slot or evicts one chosen by a not-recently-used rule. Two control inputs manage consistency. A single-page invalidate is used when a mapping's protection changes. A whole-buffer flush is used on a context switch. The block does not walk tables, check permissions or tag slots with an address-space identifier.

Top module: `xlat_cache`

## Requirements
- R1: When `lk_valid` is high and a valid slot's tag equals `lk_vaddr[VA_W-1:OFF_W]`, `lk_hit` is high and `lk_pte` shows that slot's entry in the same cycle. When `lk_valid` is high and no slot matches, `lk_miss` is high. Both flags are low when `lk_valid` is low.
- R2: On a hit, `lk_paddr` equals the entry's frame field, which is `lk_pte[PTE_W-1 -: PA_W-OFF_W]`, concatenated above `lk_vaddr[OFF_W-1:0]`.
- R3: The number of slots is the parameter `DEPTH`, meant to lie between 16 and 48, with a default of 16. All `DEPTH` slots hold distinct translations at the same time.
- R4: A cycle with `inv_en` high removes the slot whose tag equals `inv_vpn`. From the next cycle, lookups of that page miss, and all other slots stay untouched.
- R5: A cycle with `flush_en` high empties every slot. From the next cycle, every lookup misses.
- R6: When every slot is valid, a refill of a new page evicts the lowest-indexed slot whose reference bit is clear. Every hit sets the hit slot's reference bit, and so does every refill write.
- R7: A refill whose page number is already cached overwrites that slot's entry. It never leaves two slots with the same tag.
- R8: A refill of a new page goes to the lowest-indexed empty slot whenever one exists, and in that case no valid slot is evicted.
- R9: When setting a reference bit would leave every valid slot referenced, all reference bits are cleared except those being set in that cycle.
- R10: Synchronous active-low reset empties every slot and clears every reference bit.
- R11: If `flush_en` and `fill_en` are both high in one cycle, the flush wins and the refilled page is not cached afterwards.
- R12: A lookup in the same cycle as an invalidate of that page sees the state from before the invalidate and hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a valid matching slot |
| lk_miss | output | 1 | Lookup found no matching slot |
| lk_pte | output | PTE_W | Cached page-table entry of the hit slot |
| lk_paddr | output | PA_W | Translated physical address |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VA_W-OFF_W | Page number being refilled |
| fill_pte | input | PTE_W | Entry being refilled |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | VA_W-OFF_W | Page number to invalidate |
| flush_en | input | 1 | Invalidate all slots |

## Verification
Lookups are tried in several forms: hits on freshly filled pages, misses on pages never mapped, hits with a non-zero offset, and lookups that collide with an invalidate. Together these separate tag matching, entry return and address formation. Refills are tried in four cases: into an empty buffer, into a full buffer with mixed reference bits, into a buffer whose reference bits have just saturated, and into a buffer with a single hole. Checking which old page then misses identifies the victim each time, so it tells apart lowest-free, lowest-unreferenced and saturation-clearing behaviour. A refill of a page that is already present, followed by an invalidate of that page, shows whether a duplicate slot was left behind. A flush issued together with a refill shows which of the two wins.

// File: rtl/xlat_pkg.sv
// Shared defaults for the translation cache.
// Assumes: none; constants only.
package xlat_pkg;
    localparam int DEF_VA_W  = 32;
    localparam int DEF_PA_W  = 32;
    localparam int DEF_OFF_W = 12;
    localparam int DEF_PTE_W = 32;
    localparam int DEF_DEPTH = 16;
endpackage

// File: rtl/xlat_match.sv
// Parallel tag comparator: compares one key against every slot tag.
// It returns a per-slot match mask, an any-match flag and the lowest matching index.
// Assumes: tags are unique among valid slots, so at most one mask bit is set.
module xlat_match #(
    parameter int DEPTH = 16,
    parameter int KEY_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [KEY_W-1:0] key,
    input  logic [KEY_W-1:0] tags [DEPTH],
    input  logic [DEPTH-1:0] valid,
    output logic [DEPTH-1:0] mask,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // One comparator per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign mask[g] = valid[g] && (tags[g] == key);
    end

    assign any = |mask;

    // Encode the lowest set mask bit.
    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_victim.sv
// Replacement picker for refills of pages that are not cached.
// Picks the lowest empty slot first, then the lowest valid slot with a clear
// reference bit, and index 0 if neither exists.
// Assumes: the reference bits are maintained by the parent.
module xlat_victim #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] refd,
    output logic [IDX_W-1:0] idx
);
    logic [DEPTH-1:0] free_m;
    logic [DEPTH-1:0] cold_m;

    assign free_m = ~valid;
    assign cold_m = valid & ~refd;

    // Priority: lowest free slot, then lowest cold slot.
    always_comb begin
        idx = '0;
        if (|free_m) begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (free_m[i]) idx = IDX_W'(i);
            end
        end else begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (cold_m[i]) idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xlat_cache.sv
// Fully associative translation cache.
// Looks up page numbers in parallel and returns the cached entry plus the
// physical address combinationally. Accepts refills, single-page invalidates
// and a full flush, and keeps reference bits for not-recently-used replacement.
// Assumes: the frame number sits in the top PA_W-OFF_W bits of an entry.
// Within one cycle the order is: flush overrides all, the invalidate is applied,
// then the refill is written.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W  = DEF_VA_W,
    parameter int PA_W  = DEF_PA_W,
    parameter int OFF_W = DEF_OFF_W,
    parameter int PTE_W = DEF_PTE_W,
    parameter int DEPTH = DEF_DEPTH,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PFN_W = PA_W - OFF_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PTE_W-1:0] lk_pte,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PTE_W-1:0] fill_pte,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_en
);
    localparam logic [DEPTH-1:0] ONE = DEPTH'(1);

    logic [VPN_W-1:0] tag_q [DEPTH];
    logic [PTE_W-1:0] pte_q [DEPTH];
    logic [DEPTH-1:0] valid_q, ref_q;
    logic [DEPTH-1:0] valid_n, ref_n;

    logic [DEPTH-1:0] lk_mask, fl_mask, iv_mask;
    logic             lk_any, fl_any, iv_any;
    logic [IDX_W-1:0] lk_idx, fl_idx, iv_idx, vic_idx, wr_idx;

    xlat_match #(.DEPTH(DEPTH), .KEY_W(VPN_W)) i_lk_match (
        .key(lk_vaddr[VA_W-1:OFF_W]), .tags(tag_q), .valid(valid_q),
        .mask(lk_mask), .any(lk_any), .idx(lk_idx)
    );

    xlat_match #(.DEPTH(DEPTH), .KEY_W(VPN_W)) i_fl_match (
        .key(fill_vpn), .tags(tag_q), .valid(valid_q),
        .mask(fl_mask), .any(fl_any), .idx(fl_idx)
    );

    xlat_match #(.DEPTH(DEPTH), .KEY_W(VPN_W)) i_iv_match (
        .key(inv_vpn), .tags(tag_q), .valid(valid_q),
        .mask(iv_mask), .any(iv_any), .idx(iv_idx)
    );

    xlat_victim #(.DEPTH(DEPTH)) i_victim (
        .valid(valid_q), .refd(ref_q), .idx(vic_idx)
    );

    // Lookup result, formed from the current state only.
    assign lk_hit   = lk_valid && lk_any;
    assign lk_miss  = lk_valid && !lk_any;
    assign lk_pte   = lk_any ? pte_q[lk_idx] : '0;
    assign lk_paddr = {lk_pte[PTE_W-1 -: PFN_W], lk_vaddr[OFF_W-1:0]};

    // A refill goes to the slot of its own page if present, else to the victim.
    assign wr_idx = fl_any ? fl_idx : vic_idx;

    // Next valid and reference bits: invalidate, refill, then saturation rule.
    always_comb begin
        logic [DEPTH-1:0] touch;
        logic [DEPTH-1:0] setb;
        valid_n = valid_q;
        if (inv_en && iv_any) valid_n = valid_n & ~(ONE << iv_idx);
        touch = '0;
        if (lk_hit) touch = touch | (ONE << lk_idx);
        if (fill_en) begin
            valid_n = valid_n | (ONE << wr_idx);
            touch   = touch | (ONE << wr_idx);
        end
        touch = touch & valid_n;
        setb  = (ref_q & valid_n) | touch;
        if (touch != '0 && (setb & valid_n) == valid_n) ref_n = touch;
        else                                            ref_n = setb;
        if (flush_en) begin
            valid_n = '0;
            ref_n   = '0;
        end
    end

    // State bits with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ref_q   <= '0;
        end else begin
            valid_q <= valid_n;
            ref_q   <= ref_n;
        end
    end

    // Tag and entry storage, written on a refill that no flush overrides.
    always_ff @(posedge clk) begin
        if (fill_en && !flush_en) begin
            tag_q[wr_idx] <= fill_vpn;
            pte_q[wr_idx] <= fill_pte;
        end
    end
endmodule

// File: rtl/xlat_cache_chk.sv
// Property checker for xlat_cache, attached by bind.
// Assumes: it sees the top's ports and the lookup match mask.
module xlat_cache_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32,
    parameter int DEPTH = 16,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PFN_W = PA_W - OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [PTE_W-1:0] lk_pte,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             fill_en,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PTE_W-1:0] fill_pte,
    input logic             inv_en,
    input logic [VPN_W-1:0] inv_vpn,
    input logic             flush_en,
    input logic [DEPTH-1:0] lk_mask
);
    p_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid ? (lk_hit != lk_miss) : (!lk_hit && !lk_miss));

    p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    p_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[PA_W-1:OFF_W] == lk_pte[PTE_W-1 -: PFN_W]);

    p_inv_gone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !fill_en) |=>
            !(lk_hit && lk_vaddr[VA_W-1:OFF_W] == $past(inv_vpn)));

    p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> !lk_hit);

    p_fill_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_en) |=>
            (!(lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn))
             || (lk_hit && lk_pte == $past(fill_pte))));

    p_unique_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_mask));
endmodule

bind xlat_cache xlat_cache_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTE_W(PTE_W), .DEPTH(DEPTH)
) i_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pte(lk_pte), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_en(flush_en), .lk_mask(lk_mask)
);

// File: tb/test_xlat_cache.sv
// Directed bench for xlat_cache with default parameters.
module test_xlat_cache;
    localparam int VA_W = 32, PA_W = 32, OFF_W = 12, PTE_W = 32, DEPTH = 16;
    localparam int VPN_W = VA_W - OFF_W;

    logic clk = 0, rst_n = 0;
    logic lk_valid = 0, fill_en = 0, inv_en = 0, flush_en = 0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic [VPN_W-1:0] fill_vpn = '0, inv_vpn = '0;
    logic [PTE_W-1:0] fill_pte = '0;
    logic lk_hit, lk_miss;
    logic [PTE_W-1:0] lk_pte;
    logic [PA_W-1:0]  lk_paddr;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pte(lk_pte), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_en(flush_en)
    );

    function automatic logic [PTE_W-1:0] mk_pte(input logic [VPN_W-1:0] v, input logic [7:0] s);
        return {v ^ 20'hA5000 ^ {12'h0, s}, 12'h0C3};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lookup for one cycle; checks hit/miss, entry and address before the edge.
    task automatic look(input logic [VPN_W-1:0] v, input logic exp_hit,
                        input logic [PTE_W-1:0] exp_pte, input string req);
        logic [OFF_W-1:0] off;
        off = OFF_W'(12'h3C4 ^ v[11:0]);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {v, off};
        #2;
        chk(req, {62'h0, lk_hit, lk_miss}, {62'h0, exp_hit, !exp_hit});
        if (exp_hit) begin
            chk(req, 64'(lk_pte), 64'(exp_pte));
            chk(req, 64'(lk_paddr), 64'({exp_pte[PTE_W-1:OFF_W], off}));
        end
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [PTE_W-1:0] p, input logic fl);
        @(negedge clk);
        fill_en = 1; fill_vpn = v; fill_pte = p; flush_en = fl;
        @(negedge clk);
        fill_en = 0; flush_en = 0;
    endtask

    // Invalidate one page; when also_look is set, look it up in the same cycle.
    task automatic inval(input logic [VPN_W-1:0] v, input logic also_look, input logic [PTE_W-1:0] p);
        @(negedge clk);
        inv_en = 1; inv_vpn = v;
        if (also_look) begin
            lk_valid = 1; lk_vaddr = {v, 12'h010};
            #2;
            chk("R12 lookup during invalidate", {63'h0, lk_hit}, 64'h1);
            chk("R12 entry during invalidate", 64'(lk_pte), 64'(p));
        end
        @(negedge clk);
        inv_en = 0; lk_valid = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        lk_valid = 0;
        #1;
        chk("R1 idle flags", {62'h0, lk_hit, lk_miss}, 64'h0);
        look(20'h00100, 0, '0, "R10 empty after reset");
        look(20'h00000, 0, '0, "R10 empty after reset");
    endtask

    task automatic t_fill_all;
        for (int i = 0; i < DEPTH; i++) fill(VPN_W'(32'h100 + i), mk_pte(VPN_W'(32'h100 + i), 0), 0);
        look(20'h00100, 1, mk_pte(20'h00100, 0), "R1 hit slot 0");
        look(20'h00101, 1, mk_pte(20'h00101, 0), "R2 hit slot 1");
        look(20'h0010F, 1, mk_pte(20'h0010F, 0), "R3 hit last slot");
        look(20'h00999, 0, '0, "R1 unmapped miss");
    endtask

    task automatic t_nru_victim;
        // Referenced: slots 0,1,15. Victim is slot 2.
        fill(20'h00200, mk_pte(20'h00200, 1), 0);
        look(20'h00102, 0, '0, "R6 victim evicted");
        look(20'h00200, 1, mk_pte(20'h00200, 1), "R6 new page present");
        look(20'h00103, 1, mk_pte(20'h00103, 0), "R6 neighbour kept");
    endtask

    task automatic t_saturate;
        for (int i = 4; i <= 14; i++) look(VPN_W'(32'h100 + i), 1, mk_pte(VPN_W'(32'h100 + i), 0), "R9 hit");
        // Hitting slot 14 saturated the bits; only slot 14 remains referenced.
        fill(20'h00201, mk_pte(20'h00201, 2), 0);
        look(20'h00100, 0, '0, "R9 slot 0 evicted after saturation");
        look(20'h00201, 1, mk_pte(20'h00201, 2), "R9 new page present");
        look(20'h00101, 1, mk_pte(20'h00101, 0), "R9 slot 1 kept");
    endtask

    task automatic t_overwrite;
        fill(20'h00105, mk_pte(20'h00105, 7), 0);
        look(20'h00105, 1, mk_pte(20'h00105, 7), "R7 overwritten entry");
        inval(20'h00105, 0, '0);
        look(20'h00105, 0, '0, "R7 no duplicate left");
        look(20'h00106, 1, mk_pte(20'h00106, 0), "R4 other slot untouched");
    endtask

    task automatic t_hole;
        // Slot 5 is empty; slot 2 is valid with a clear reference bit.
        fill(20'h00202, mk_pte(20'h00202, 3), 0);
        look(20'h00200, 1, mk_pte(20'h00200, 1), "R8 unreferenced slot kept");
        look(20'h00202, 1, mk_pte(20'h00202, 3), "R8 refill into hole");
    endtask

    task automatic t_inv_same_cycle;
        inval(20'h00108, 1, mk_pte(20'h00108, 0));
        look(20'h00108, 0, '0, "R4 page invalidated");
        look(20'h00109, 1, mk_pte(20'h00109, 0), "R4 neighbour untouched");
    endtask

    task automatic t_flush;
        fill(20'h00300, mk_pte(20'h00300, 4), 1);
        look(20'h00300, 0, '0, "R11 flush beats refill");
        look(20'h00101, 0, '0, "R5 flushed");
        look(20'h00201, 0, '0, "R5 flushed");
        fill(20'h00301, mk_pte(20'h00301, 5), 0);
        look(20'h00301, 1, mk_pte(20'h00301, 5), "R5 usable after flush");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_fill_all();
        t_nru_victim();
        t_saturate();
        t_overwrite();
        t_hole();
        t_inv_same_cycle();
        t_flush();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule